// File: doc/BRIEF.md
# Byte-to-Word FIFO Data Engine

This block sits between a host that moves 32-bit words and a card-side link that carries one byte per handshake. A circular FIFO of word entries is shared by both directions. When data flows from the card, incoming bytes are packed little-endian into words and pushed into the FIFO for the host to pop. When data flows to the card, host-pushed words are unpacked low byte first onto the outgoing byte stream.

A transfer is armed by a one-cycle `start` pulse. The pulse loads a byte countdown from `len` and latches the direction. The countdown, not the word count, decides when the transfer ends, so a transfer may stop part way through a word. The block raises a status vector built from FIFO occupancy, and only the half of that vector belonging to the active direction is ever non-zero. The enable (`busy`) drops by itself once the countdown is exhausted and the FIFO has drained.

Top module: `wbe_engine`

## Requirements
- R1: After reset, `status` is 0, `busy`, `pop_err`, `rx_ready` and `tx_valid` are 0, and `bytes_left` is 0.
- R2: A `start` pulse loads `bytes_left` from `len`, latches `dir_rx` (1 = card to host, 0 = host to card), and sets `busy` from the next cycle on.
- R3: Card to host, bytes are packed little-endian: the first byte of a word lands in bits 7:0 and the fourth in bits 31:24. A word is pushed when its fourth byte arrives, or earlier when the countdown reaches zero, in which case the unfilled upper bytes are zero.
- R4: `rx_ready` is high only while busy in the card-to-host direction with `card_rdy` high, `bytes_left` nonzero and the FIFO not holding 16 words.
- R5: `bytes_left` falls by exactly one for each completed byte handshake on either card-side stream, and changes in no other way except on `start`.
- R6: Host to card, bytes leave low byte first. A new word is taken from the FIFO only once the previous word's four bytes are used up, and bytes left in a word when the countdown reaches zero are dropped.
- R7: `status[0]` (data end) and `status[1]` (block end) rise the cycle after `bytes_left` becomes zero while busy and hold until the next `start`. `busy` clears one cycle after `bytes_left` is zero and the FIFO is empty.
- R8: While busy and not (count zero and FIFO empty), with occupancy L: active is set, empty when L = 0, data-available when L > 0, full when L = 16, transmit half-empty when L <= 8, receive half-full when L >= 8. Otherwise all these flags are 0.
- R9: Transmit flags sit at bits 2 (active), 4 (empty), 6 (available), 8 (full), 10 (half-empty). Receive flags sit at bits 3 (active), 5 (empty), 7 (available), 9 (full), 11 (half-full). Only the group of the latched direction is ever non-zero.
- R10: A word push into a full FIFO is dropped. A host pop from an empty FIFO in the card-to-host direction returns 0 and sets `pop_err`, which holds until the next `start`.
- R11: The host ports follow the latched direction: `host_push` is ignored when card to host, and `host_pop` when host to card returns 0 without setting `pop_err`.
- R12: A host pop and a packer push in the same cycle both take effect, leaving occupancy unchanged and word order intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that arms a transfer |
| dir_rx | input | 1 | Direction sampled on start: 1 card to host, 0 host to card |
| len | input | 16 | Transfer length in bytes, sampled on start |
| busy | output | 1 | Transfer enable, self-clearing |
| bytes_left | output | 16 | Remaining byte countdown |
| host_push | input | 1 | Host pushes `host_wdata` this cycle |
| host_wdata | input | 32 | Word pushed by the host |
| host_pop | input | 1 | Host pops the head word this cycle |
| host_rdata | output | 32 | Head word, valid in the cycle of `host_pop` |
| pop_err | output | 1 | Sticky empty-pop indication |
| card_rdy | input | 1 | Card has read data ready |
| rx_valid | input | 1 | Card-to-host byte valid |
| rx_data | input | 8 | Card-to-host byte |
| rx_ready | output | 1 | Engine accepts a card byte |
| tx_valid | output | 1 | Host-to-card byte valid |
| tx_data | output | 8 | Host-to-card byte |
| tx_ready | input | 1 | Card accepts the outgoing byte |
| status | output | 12 | Completion and occupancy flags |

## Verification
The two functions that can meet in one cycle are a host pop and the packer's push of a completed word. The bench fills the FIFO to 16 words, pops one, then presents the byte that completes the next word in the same cycle as a second pop. It judges the result by the popped word, by the full flag staying low at 15 entries, and by the FIFO reaching full again after exactly one more word, with every later word arriving in order.

// File: rtl/wbe_pkg.sv
package wbe_pkg;
   localparam int ST_W        = 12;
   localparam int ST_DATA_END = 0;
   localparam int ST_BLK_END  = 1;
   localparam int ST_TX_ACT   = 2;
   localparam int ST_RX_ACT   = 3;
   localparam int ST_TX_EMPTY = 4;
   localparam int ST_RX_EMPTY = 5;
   localparam int ST_TX_AVAIL = 6;
   localparam int ST_RX_AVAIL = 7;
   localparam int ST_TX_FULL  = 8;
   localparam int ST_RX_FULL  = 9;
   localparam int ST_TX_HALF  = 10;
   localparam int ST_RX_HALF  = 11;

   localparam logic [ST_W-1:0] TX_GROUP = 12'h554;
   localparam logic [ST_W-1:0] RX_GROUP = 12'hAA8;

   typedef enum logic {DIR_TO_CARD = 1'b0, DIR_FROM_CARD = 1'b1} dir_e;
endpackage

// File: rtl/wbe_fifo.sv
module wbe_fifo #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] push_data,
   input  logic              pop,
   output logic [WORD_W-1:0] head,
   output logic [CNT_W-1:0]  level,
   output logic              push_ok,
   output logic              pop_ok
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  rd_q;
   logic [PTR_W-1:0]  wr_slot;
   logic [PTR_W-1:0]  rd_next;
   logic [CNT_W-1:0]  cnt_q;

   assign push_ok = push && (cnt_q != CNT_W'(DEPTH));
   assign pop_ok  = pop && (cnt_q != '0);
   assign head    = mem[rd_q];
   assign level   = cnt_q;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_slot = rd_q + cnt_q[PTR_W-1:0];
         assign rd_next = rd_q + 1'b1;
      end else begin : g_modulo
         assign wr_slot = PTR_W'((int'(rd_q) + int'(cnt_q)) % DEPTH);
         assign rd_next = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_slot] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (pop_ok) rd_q <= rd_next;
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));
   p_full_push_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (push && cnt_q == CNT_W'(DEPTH) && !pop) |=> cnt_q == CNT_W'(DEPTH));
   p_both_level_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && pop_ok) |=> $stable(cnt_q));
endmodule

// File: rtl/wbe_rx_pack.sv
module wbe_rx_pack #(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8,
   localparam int LANES  = WORD_W / BYTE_W,
   localparam int LANE_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fire,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              last_byte,
   output logic              word_push,
   output logic [WORD_W-1:0] word_out
);
   logic [WORD_W-1:0] acc_q;
   logic [LANE_W-1:0] lane_q;
   logic [WORD_W-1:0] merged;

   always_comb begin
      merged = acc_q;
      merged[int'(lane_q)*BYTE_W +: BYTE_W] = byte_in;
   end

   assign word_push = fire && (last_byte || lane_q == LANE_W'(LANES - 1));
   assign word_out  = merged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         lane_q <= '0;
      end else if (clr || word_push) begin
         acc_q  <= '0;
         lane_q <= '0;
      end else if (fire) begin
         acc_q  <= merged;
         lane_q <= lane_q + 1'b1;
      end
   end

   p_fresh_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      word_push |=> (lane_q == '0 && acc_q == '0));
endmodule

// File: rtl/wbe_tx_unpack.sv
module wbe_tx_unpack #(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8,
   localparam int LANES = WORD_W / BYTE_W,
   localparam int REM_W = $clog2(LANES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic              fifo_empty,
   input  logic [WORD_W-1:0] head,
   input  logic              ready,
   output logic              valid,
   output logic [BYTE_W-1:0] byte_out,
   output logic              pop
);
   logic [WORD_W-1:0] shr_q;
   logic [REM_W-1:0]  rem_q;
   logic              fire;

   assign valid    = en && (rem_q != '0 || !fifo_empty);
   assign byte_out = (rem_q != '0) ? shr_q[BYTE_W-1:0] : head[BYTE_W-1:0];
   assign fire     = valid && ready;
   assign pop      = fire && rem_q == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shr_q <= '0;
         rem_q <= '0;
      end else if (clr) begin
         shr_q <= '0;
         rem_q <= '0;
      end else if (fire) begin
         if (rem_q == '0) begin
            shr_q <= head >> BYTE_W;
            rem_q <= REM_W'(LANES - 1);
         end else begin
            shr_q <= shr_q >> BYTE_W;
            rem_q <= rem_q - 1'b1;
         end
      end
   end

   p_rem_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rem_q <= REM_W'(LANES - 1));
endmodule

// File: rtl/wbe_status.sv
module wbe_status
   import wbe_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             busy,
   input  logic             dir_rx,
   input  logic             cnt_zero,
   input  logic [CNT_W-1:0] level,
   output logic [ST_W-1:0]  status
);
   logic            done_q;
   logic            show;
   logic [ST_W-1:0] raw;

   assign show = busy && !(cnt_zero && level == '0);

   always_comb begin
      raw = '0;
      raw[ST_TX_ACT]   = show;
      raw[ST_RX_ACT]   = show;
      raw[ST_TX_EMPTY] = show && level == '0;
      raw[ST_RX_EMPTY] = show && level == '0;
      raw[ST_TX_AVAIL] = show && level != '0;
      raw[ST_RX_AVAIL] = show && level != '0;
      raw[ST_TX_FULL]  = show && level == CNT_W'(DEPTH);
      raw[ST_RX_FULL]  = show && level == CNT_W'(DEPTH);
      raw[ST_TX_HALF]  = show && level <= CNT_W'(DEPTH / 2);
      raw[ST_RX_HALF]  = show && level >= CNT_W'(DEPTH / 2);
      status = raw & (dir_rx ? RX_GROUP : TX_GROUP);
      status[ST_DATA_END] = done_q;
      status[ST_BLK_END]  = done_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      done_q <= 1'b0;
      else if (clr)    done_q <= 1'b0;
      else if (busy && cnt_zero) done_q <= 1'b1;
   end

   p_one_group_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(status & RX_GROUP) && |(status & TX_GROUP)));
   p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !clr) |=> done_q);
endmodule

// File: rtl/wbe_engine.sv
module wbe_engine
   import wbe_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 16,
   parameter int LEN_W  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dir_rx,
   input  logic [LEN_W-1:0]  len,
   output logic              busy,
   output logic [LEN_W-1:0]  bytes_left,
   input  logic              host_push,
   input  logic [WORD_W-1:0] host_wdata,
   input  logic              host_pop,
   output logic [WORD_W-1:0] host_rdata,
   output logic              pop_err,
   input  logic              card_rdy,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data,
   input  logic              tx_ready,
   output logic [ST_W-1:0]   status
);
   generate
      if (WORD_W % BYTE_W != 0 || WORD_W / BYTE_W < 2) begin : g_bad_lanes
         $error("WORD_W must hold at least two whole bytes");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
   endgenerate

   dir_e             dir_q;
   logic             busy_q;
   logic [LEN_W-1:0] cnt_q;
   logic             err_q;
   logic             cnt_zero;
   logic             act_rx;
   logic             act_tx;
   logic             rx_fire;
   logic             tx_fire;

   logic              f_push;
   logic [WORD_W-1:0] f_wdata;
   logic              f_pop;
   logic [WORD_W-1:0] f_head;
   logic [CNT_W-1:0]  f_level;
   logic              f_push_ok;
   logic              f_pop_ok;
   logic              f_empty;
   logic              f_full;

   logic              pk_push;
   logic [WORD_W-1:0] pk_word;
   logic              up_pop;

   assign cnt_zero = cnt_q == '0;
   assign act_rx   = busy_q && dir_q == DIR_FROM_CARD;
   assign act_tx   = busy_q && dir_q == DIR_TO_CARD;
   assign f_empty  = f_level == '0;
   assign f_full   = f_level == CNT_W'(DEPTH);

   assign rx_ready = act_rx && card_rdy && !cnt_zero && !f_full;
   assign rx_fire  = rx_valid && rx_ready;
   assign tx_fire  = tx_valid && tx_ready;

   assign f_push  = (dir_q == DIR_FROM_CARD) ? pk_push : host_push;
   assign f_wdata = (dir_q == DIR_FROM_CARD) ? pk_word : host_wdata;
   assign f_pop   = (dir_q == DIR_FROM_CARD) ? host_pop : up_pop;

   assign host_rdata = (dir_q == DIR_FROM_CARD && !f_empty) ? f_head : '0;
   assign busy       = busy_q;
   assign bytes_left = cnt_q;
   assign pop_err    = err_q;

   wbe_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(f_push), .push_data(f_wdata), .pop(f_pop),
      .head(f_head), .level(f_level), .push_ok(f_push_ok), .pop_ok(f_pop_ok)
   );

   wbe_rx_pack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .clr(start), .fire(rx_fire),
      .byte_in(rx_data), .last_byte(cnt_q == LEN_W'(1)),
      .word_push(pk_push), .word_out(pk_word)
   );

   wbe_tx_unpack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_unpack (
      .clk(clk), .rst_n(rst_n), .clr(start), .en(act_tx && !cnt_zero),
      .fifo_empty(f_empty), .head(f_head), .ready(tx_ready),
      .valid(tx_valid), .byte_out(tx_data), .pop(up_pop)
   );

   wbe_status #(.DEPTH(DEPTH)) u_status (
      .clk(clk), .rst_n(rst_n), .clr(start), .busy(busy_q),
      .dir_rx(dir_q == DIR_FROM_CARD), .cnt_zero(cnt_zero),
      .level(f_level), .status(status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= DIR_TO_CARD;
         busy_q <= 1'b0;
         cnt_q  <= '0;
         err_q  <= 1'b0;
      end else if (start) begin
         dir_q  <= dir_rx ? DIR_FROM_CARD : DIR_TO_CARD;
         busy_q <= 1'b1;
         cnt_q  <= len;
         err_q  <= 1'b0;
      end else begin
         if (cnt_zero && f_empty) busy_q <= 1'b0;
         if (rx_fire || tx_fire)  cnt_q  <= cnt_q - 1'b1;
         if (host_pop && dir_q == DIR_FROM_CARD && f_empty) err_q <= 1'b1;
      end
   end

   p_zero_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_zero && !start) |=> cnt_zero);
   p_rx_push_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pk_push |-> f_push_ok);
   p_tx_pop_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      up_pop |-> f_pop_ok);
   p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(cnt_zero && f_empty));
   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !start) |=> err_q);
   p_no_rx_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      f_full |-> !rx_ready);
endmodule

// File: tb/wbe_engine_bench.sv
module wbe_engine_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        dir_rx = 1'b0;
   logic [15:0] len = '0;
   logic        busy;
   logic [15:0] bytes_left;
   logic        host_push = 1'b0;
   logic [31:0] host_wdata = '0;
   logic        host_pop = 1'b0;
   logic [31:0] host_rdata;
   logic        pop_err;
   logic        card_rdy = 1'b1;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_ready;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b0;
   logic [11:0] status;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wbe_engine u_wbe_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .dir_rx(dir_rx), .len(len),
      .busy(busy), .bytes_left(bytes_left),
      .host_push(host_push), .host_wdata(host_wdata),
      .host_pop(host_pop), .host_rdata(host_rdata), .pop_err(pop_err),
      .card_rdy(card_rdy), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .status(status)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_start(input logic d, input logic [15:0] l);
      start = 1'b1; dir_rx = d; len = l;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      rx_valid = 1'b1; rx_data = b;
      #1;
      while (!rx_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic pop_word(output logic [31:0] w);
      host_pop = 1'b1;
      #1 w = host_rdata;
      @(negedge clk);
      host_pop = 1'b0;
   endtask

   task automatic push_word(input logic [31:0] w);
      host_push = 1'b1; host_wdata = w;
      @(negedge clk);
      host_push = 1'b0;
   endtask

   task automatic recv_byte(output logic [7:0] b);
      tx_ready = 1'b1;
      #1;
      while (!tx_valid) begin @(negedge clk); #1; end
      b = tx_data;
      @(negedge clk);
      tx_ready = 1'b0;
   endtask

   function automatic logic [31:0] seq_word(input int k);
      return {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)};
   endfunction

   task automatic t_reset();
      chk("R1 status", 32'(status), 32'h0);
      chk("R1 busy", 32'(busy), 32'h0);
      chk("R1 pop_err", 32'(pop_err), 32'h0);
      chk("R1 rx_ready", 32'(rx_ready), 32'h0);
      chk("R1 tx_valid", 32'(tx_valid), 32'h0);
      chk("R1 bytes_left", 32'(bytes_left), 32'h0);
   endtask

   task automatic t_rx_basic();
      logic [31:0] w;
      do_start(1'b1, 16'd6);
      chk("R2 bytes_left loaded", 32'(bytes_left), 32'd6);
      chk("R2 busy", 32'(busy), 32'h1);
      chk("R8 R9 rx empty flags", 32'(status), 32'h028);
      send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
      chk("R5 bytes_left after 4", 32'(bytes_left), 32'd2);
      chk("R8 R9 rx avail flags", 32'(status), 32'h088);
      send_byte(8'h55); send_byte(8'h66);
      chk("R5 bytes_left zero", 32'(bytes_left), 32'd0);
      chk("R4 no ready at count zero", 32'(rx_ready), 32'h0);
      idle(1);
      chk("R7 data end set", 32'(status), 32'h08B);
      pop_word(w); chk("R3 full word little-endian", w, 32'h44332211);
      pop_word(w); chk("R3 partial word zero-filled", w, 32'h00006655);
      idle(2);
      chk("R7 busy self-clears", 32'(busy), 32'h0);
      chk("R7 end flags held", 32'(status), 32'h003);
      pop_word(w);
      chk("R10 empty pop data", w, 32'h0);
      chk("R10 empty pop error", 32'(pop_err), 32'h1);
      idle(1);
      chk("R10 error sticky", 32'(pop_err), 32'h1);
   endtask

   task automatic t_rx_card_wait();
      logic [31:0] w;
      do_start(1'b1, 16'd4);
      chk("R10 error cleared by start", 32'(pop_err), 32'h0);
      card_rdy = 1'b0; rx_valid = 1'b1; rx_data = 8'hEE;
      idle(3);
      chk("R4 no ready without card data", 32'(rx_ready), 32'h0);
      chk("R5 count holds without handshake", 32'(bytes_left), 32'd4);
      rx_valid = 1'b0; card_rdy = 1'b1;
      send_byte(8'hA0); send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hA3);
      pop_word(w);
      chk("R3 word after card wait", w, 32'hA3A2A1A0);
      idle(2);
   endtask

   task automatic t_rx_full_and_overlap();
      logic [31:0] w;
      do_start(1'b1, 16'd72);
      for (int i = 0; i < 64; i++) send_byte(8'(i));
      #1;
      chk("R4 no ready when full", 32'(rx_ready), 32'h0);
      chk("R8 rx full flags", 32'(status), 32'hA88);
      pop_word(w); chk("R3 first word", w, seq_word(0));
      chk("R4 ready after pop", 32'(rx_ready), 32'h1);
      send_byte(8'd64); send_byte(8'd65); send_byte(8'd66);
      rx_valid = 1'b1; rx_data = 8'd67; host_pop = 1'b1;
      #1 w = host_rdata;
      chk("R12 ready during overlap", 32'(rx_ready), 32'h1);
      @(negedge clk);
      rx_valid = 1'b0; host_pop = 1'b0;
      chk("R12 popped word in overlap", w, seq_word(1));
      chk("R12 level kept at 15", 32'(status), 32'hA88 & ~32'h200);
      for (int i = 68; i < 72; i++) send_byte(8'(i));
      chk("R12 full again after one word", 32'(status[9]), 32'h1);
      chk("R5 count done", 32'(bytes_left), 32'd0);
      for (int k = 2; k < 18; k++) begin
         pop_word(w);
         chk("R12 order kept", w, seq_word(k));
      end
      idle(2);
      chk("R7 busy off after drain", 32'(busy), 32'h0);
   endtask

   task automatic t_tx_basic();
      logic [31:0] w;
      logic [7:0]  b;
      logic [7:0]  exp_b [6];
      exp_b = '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hB1, 8'hB2};
      do_start(1'b0, 16'd6);
      chk("R8 R9 tx empty flags", 32'(status), 32'h414);
      #1 chk("R6 no byte without word", 32'(tx_valid), 32'h0);
      pop_word(w);
      chk("R11 pop ignored toward card", w, 32'h0);
      chk("R11 no error toward card", 32'(pop_err), 32'h0);
      push_word(32'hA4A3A2A1);
      push_word(32'hB4B3B2B1);
      chk("R8 R9 tx avail flags", 32'(status), 32'h444);
      for (int i = 0; i < 6; i++) begin
         recv_byte(b);
         chk("R6 byte order", 32'(b), 32'(exp_b[i]));
      end
      #1 chk("R6 stream stops mid-word", 32'(tx_valid), 32'h0);
      idle(2);
      chk("R6 leftover bytes dropped", 32'(busy), 32'h0);
      chk("R7 tx end flags", 32'(status), 32'h003);
   endtask

   task automatic t_tx_overflow();
      logic [7:0] b;
      do_start(1'b0, 16'd68);
      for (int k = 0; k < 17; k++) push_word(32'h5000_0000 + 32'(k * 32'h0001_0203));
      chk("R8 tx full flags", 32'(status), 32'h144);
      for (int j = 0; j < 64; j++) begin
         logic [31:0] ew;
         ew = 32'h5000_0000 + 32'((j / 4) * 32'h0001_0203);
         recv_byte(b);
         chk("R10 R6 stored byte", 32'(b), 32'(ew[(j % 4)*8 +: 8]));
      end
      #1 chk("R10 push into full dropped", 32'(tx_valid), 32'h0);
      chk("R5 count after 64 bytes", 32'(bytes_left), 32'd4);
   endtask

   task automatic t_zero_len_rx_push();
      logic [31:0] w;
      do_start(1'b1, 16'd0);
      push_word(32'hDEADBEEF);
      idle(1);
      chk("R7 zero length ends", 32'(busy), 32'h0);
      chk("R7 zero length end flags", 32'(status), 32'h003);
      pop_word(w);
      chk("R11 host push ignored from card", w, 32'h0);
      chk("R11 fifo stayed empty", 32'(pop_err), 32'h1);
   endtask

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      idle(2);
      #1 t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rx_basic();
      t_rx_card_wait();
      t_rx_full_and_overlap();
      t_tx_basic();
      t_tx_overflow();
      t_zero_len_rx_push();
      summary();
   end
endmodule